// File: doc/BRIEF.md
# Page-Buffered Programming Controller for a Serial EEPROM

This block sits between a serial-bus slave front end and a byte-wide storage array. While a write transaction is in progress, the front end hands over each received data byte with a strobe. The first byte of a transaction also carries the target word address. The controller stores the bytes in a 16-entry page buffer. A per-slot valid mask records which slots were loaded. The buffer slot advances through the low four address bits only, so a burst longer than a page wraps around inside the same page. A later byte then replaces the one already held in that slot.

Nothing reaches the array until the front end signals STOP. On STOP, with at least one byte buffered and write protection off, the controller starts one self-timed programming cycle and raises `busy_o`. The cycle length is a parameterised number of clocks and stands in for the few-millisecond internal write. In the first clocks of that window the controller drains the loaded slots to the array write port, one slot per clock in ascending slot order. While busy, every byte and STOP strobe is ignored, so the front end can answer acknowledge polling from `busy_o` alone. A STOP with an empty buffer, such as the dummy write before a random read, does nothing. A STOP that arrives while write protection is on discards the buffer.

Top module: `eep_page_prog`

## Requirements
- R1: After reset, `busy_o` and `mem_we_o` are low, and a STOP with no preceding bytes starts nothing.
- R2: A byte strobe with `byte_first_i` high latches the upper address bits (`byte_addr_i[ADDR_W-1:4]`) as the page and stores the byte in slot `byte_addr_i[3:0]`. At commit, slot s is written to address {page, s}.
- R3: Each later byte of the transaction goes to the previous slot plus one, modulo 16. The page bits never change, even when the slot index passes 15 and returns to 0.
- R4: When more than 16 bytes arrive before STOP, a byte whose slot is already loaded replaces it, and only the newest value of each slot is committed.
- R5: No array write occurs before STOP. `busy_o` rises on the clock edge that samples the accepted STOP and stays high for exactly PROG_CYCLES clocks. A byte strobe in the same cycle as STOP is dropped.
- R6: During the programming window, exactly the loaded slots are written, one per clock, in ascending slot order, starting in the first busy cycle. `mem_we_o` is never high outside `busy_o`.
- R7: A STOP with no bytes buffered does not raise `busy_o` and writes nothing.
- R8: If `wp_i` is high in the STOP cycle, nothing is written and `busy_o` stays low. The buffered bytes are discarded, so a later STOP with protection off also writes nothing.
- R9: While `busy_o` is high, byte strobes and STOP strobes are ignored. Bytes sent during the window are neither buffered nor committed later.
- R10: The valid mask is cleared on the edge where `busy_o` falls, so a STOP right after the window starts no second cycle.
- R11: A byte strobe with `byte_first_i` high discards any bytes still buffered from an unfinished transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld_i | input | 1 | One-cycle strobe: a received data byte is present |
| byte_first_i | input | 1 | Marks the first data byte of a transaction; qualifies `byte_addr_i` |
| byte_addr_i | input | ADDR_W | Word address of the first byte |
| byte_data_i | input | DATA_W | Received data byte |
| stop_i | input | 1 | One-cycle strobe: STOP condition seen on the bus |
| wp_i | input | 1 | Write protect; high blocks programming |
| busy_o | output | 1 | Programming cycle in progress; the front end must not acknowledge |
| mem_we_o | output | 1 | Array write enable, one byte per clock |
| mem_addr_o | output | ADDR_W | Array write address |
| mem_wdata_o | output | DATA_W | Array write data |

## Verification
A corrupted slot pointer shows up in the first commit after it occurs. The write port then shows a wrong low address nibble, or a missing or extra write, within 16 clocks of `busy_o` rising. A stale page register shows as wrong upper address bits on every write of the burst. A valid mask that is not cleared on time shows as a second busy window after the next bare STOP. A mask that is not set for a loaded slot shows as a missing write in the drain order. A faulty cycle counter shows directly as a busy width other than PROG_CYCLES.

// File: rtl/eep_pkg.sv
package eep_pkg;

    // Phase of the self-timed programming sequencer
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_PROG = 1'b1
    } prog_ph_e;

endpackage

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8,
    parameter int OFS_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en_i,
    input  logic                    first_i,
    input  logic [ADDR_W-1:0]       addr_i,
    input  logic [DATA_W-1:0]       data_i,
    input  logic                    clr_i,
    input  logic [OFS_W-1:0]        rd_idx_i,
    output logic [DATA_W-1:0]       rd_data_o,
    output logic                    rd_vld_o,
    output logic [ADDR_W-OFS_W-1:0] page_o,
    output logic                    any_o
);

    localparam int SLOTS  = 1 << OFS_W;
    localparam int PAGE_W = ADDR_W - OFS_W;

    typedef struct packed {
        logic [SLOTS-1:0][DATA_W-1:0] data;
        logic [SLOTS-1:0]             mask;
        logic [OFS_W-1:0]             ptr;
        logic [PAGE_W-1:0]            page;
    } buf_st_t;

    buf_st_t          st_d, st_q;
    logic [OFS_W-1:0] slot;

    always_comb begin
        st_d = st_q;
        slot = st_q.ptr;
        if (clr_i) begin
            st_d.mask = '0;
        end
        if (wr_en_i) begin
            if (first_i) begin
                st_d.mask = '0;
                st_d.page = addr_i[ADDR_W-1:OFS_W];
                slot      = addr_i[OFS_W-1:0];
            end
            st_d.data[slot] = data_i;
            st_d.mask[slot] = 1'b1;
            st_d.ptr        = slot + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data_o = st_q.data[rd_idx_i];
    assign rd_vld_o  = st_q.mask[rd_idx_i];
    assign page_o    = st_q.page;
    assign any_o     = |st_q.mask;

    // R6: a slot that just took a byte is marked for commit
    p_slot_marked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && !clr_i) |=> st_q.mask[$past(slot)]);

    // R3: the page bits only move on a first byte
    p_page_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_i && first_i) |=> $stable(st_q.page));

endmodule

// File: rtl/eep_prog_timer.sv
module eep_prog_timer
    import eep_pkg::*;
#(
    parameter int PROG_CYCLES = 250000,
    parameter int SLOTS       = 16,
    parameter int OFS_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    output logic             busy_o,
    output logic             drain_o,
    output logic [OFS_W-1:0] slot_o,
    output logic             done_o
);

    localparam int          CW   = $clog2(PROG_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(PROG_CYCLES - 1);
    localparam logic [CW-1:0] NSL  = CW'(SLOTS);

    typedef struct packed {
        prog_ph_e      ph;
        logic [CW-1:0] cnt;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    logic    done;

    always_comb begin
        st_d = st_q;
        done = 1'b0;
        case (st_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.ph  = PH_PROG;
                    st_d.cnt = '0;
                end
            end
            PH_PROG: begin
                if (st_q.cnt == LAST) begin
                    st_d.ph = PH_IDLE;
                    done    = 1'b1;
                end else begin
                    st_d.cnt = st_q.cnt + 1'b1;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ph: PH_IDLE, cnt: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o  = (st_q.ph == PH_PROG);
    assign drain_o = busy_o && (st_q.cnt < NSL);
    assign slot_o  = st_q.cnt[OFS_W-1:0];
    assign done_o  = done;

    // R5: busy only begins after a start request
    p_busy_from_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));

    // R5: the window cannot end early
    p_busy_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

endmodule

// File: rtl/eep_page_prog.sv
module eep_page_prog #(
    parameter int ADDR_W      = 11,
    parameter int DATA_W      = 8,
    parameter int PAGE_BYTES  = 16,
    parameter int PROG_CYCLES = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld_i,
    input  logic              byte_first_i,
    input  logic [ADDR_W-1:0] byte_addr_i,
    input  logic [DATA_W-1:0] byte_data_i,
    input  logic              stop_i,
    input  logic              wp_i,
    output logic              busy_o,
    output logic              mem_we_o,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic [DATA_W-1:0] mem_wdata_o
);

    localparam int OFS_W  = $clog2(PAGE_BYTES);
    localparam int PAGE_W = ADDR_W - OFS_W;

    logic              busy, drain, done;
    logic              take_byte, stop_ok, start, clr;
    logic [OFS_W-1:0]  slot;
    logic [DATA_W-1:0] rd_data;
    logic              rd_vld, any;
    logic [PAGE_W-1:0] page;

    // Strobes are ignored while programming; STOP wins over a same-cycle byte
    assign take_byte = byte_vld_i && !busy && !stop_i;
    assign stop_ok   = stop_i && !busy;
    assign start     = stop_ok && any && !wp_i;
    assign clr       = done || (stop_ok && !start);

    eep_page_buf #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .OFS_W  (OFS_W)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (take_byte),
        .first_i   (byte_first_i),
        .addr_i    (byte_addr_i),
        .data_i    (byte_data_i),
        .clr_i     (clr),
        .rd_idx_i  (slot),
        .rd_data_o (rd_data),
        .rd_vld_o  (rd_vld),
        .page_o    (page),
        .any_o     (any)
    );

    eep_prog_timer #(
        .PROG_CYCLES (PROG_CYCLES),
        .SLOTS       (PAGE_BYTES),
        .OFS_W       (OFS_W)
    ) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .busy_o  (busy),
        .drain_o (drain),
        .slot_o  (slot),
        .done_o  (done)
    );

    assign busy_o      = busy;
    assign mem_we_o    = drain && rd_vld;
    assign mem_addr_o  = {page, slot};
    assign mem_wdata_o = rd_data;

    // R6: array writes stay inside the programming window
    p_we_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> busy_o);

    // R7: a STOP on an empty buffer leaves busy low
    p_empty_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !busy_o && !any) |=> !busy_o);

    // R8: protection at STOP blocks the cycle
    p_wp_blocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !busy_o && wp_i) |=> !busy_o);

    // R9: the buffer is frozen while programming
    p_frozen_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done) |=> ($stable(page) && $stable(any)));

    // R10: mask empty once busy falls
    p_clear_at_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !any);

endmodule

// File: tb/eep_page_prog_tb.sv
module eep_page_prog_tb_top;

    localparam int ADDR_W = 11;
    localparam int DATA_W = 8;
    localparam int PROG   = 24;

    typedef struct packed {
        logic [10:0] addr;
        logic [4:0]  n;
        logic        wp;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [0:NV-1] = '{
        '{11'h123, 5'd1,  1'b0},
        '{11'h2A5, 5'd4,  1'b0},
        '{11'h3FC, 5'd6,  1'b0},
        '{11'h070, 5'd16, 1'b0},
        '{11'h5F3, 5'd20, 1'b0},
        '{11'h100, 5'd3,  1'b1},
        '{11'h7FE, 5'd0,  1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              byte_vld = 1'b0, byte_first = 1'b0, stop = 1'b0, wp = 1'b0;
    logic [ADDR_W-1:0] byte_addr = '0;
    logic [DATA_W-1:0] byte_data = '0;
    logic              busy, mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [DATA_W-1:0] mem_wdata;

    int total = 0;
    int fails = 0;
    logic [ADDR_W-1:0] wlog_a [64];
    logic [DATA_W-1:0] wlog_d [64];
    int wlog_n = 0;

    always #10 clk = ~clk;

    eep_page_prog #(
        .ADDR_W      (ADDR_W),
        .DATA_W      (DATA_W),
        .PAGE_BYTES  (16),
        .PROG_CYCLES (PROG)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .byte_vld_i   (byte_vld),
        .byte_first_i (byte_first),
        .byte_addr_i  (byte_addr),
        .byte_data_i  (byte_data),
        .stop_i       (stop),
        .wp_i         (wp),
        .busy_o       (busy),
        .mem_we_o     (mem_we),
        .mem_addr_o   (mem_addr),
        .mem_wdata_o  (mem_wdata)
    );

    always @(negedge clk) begin
        if (mem_we && wlog_n < 64) begin
            wlog_a[wlog_n] = mem_addr;
            wlog_d[wlog_n] = mem_wdata;
            wlog_n++;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put_byte(input logic first, input logic [ADDR_W-1:0] a,
                            input logic [DATA_W-1:0] d);
        byte_vld = 1'b1; byte_first = first; byte_addr = a; byte_data = d;
        @(negedge clk);
        byte_vld = 1'b0; byte_first = 1'b0;
    endtask

    task automatic pulse_stop();
        stop = 1'b1;
        @(negedge clk);
        stop = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_vec(input vec_t v, input int seed);
        logic [DATA_W-1:0] exp_d [16];
        bit                exp_v [16];
        int exp_n, len, k;
        bit exp_busy, saw_busy;
        logic [3:0] s;
        for (int i = 0; i < 16; i++) begin exp_v[i] = 0; exp_d[i] = '0; end
        wlog_n = 0;
        for (int i = 0; i < int'(v.n); i++) begin
            logic [DATA_W-1:0] d;
            d = 8'(seed + i * 5 + 1);
            s = v.addr[3:0] + 4'(i);
            exp_v[s] = 1; exp_d[s] = d;
            put_byte(i == 0, v.addr, d);
        end
        chk(wlog_n == 0 && !busy, "R5 nothing written before STOP", wlog_n, 0);
        wp = v.wp;
        pulse_stop();
        wp = 1'b0;
        exp_busy = (v.n != 0) && !v.wp;
        chk(busy == exp_busy, "R5/R7/R8 busy after STOP", busy, exp_busy);
        if (exp_busy) begin
            len = 0;
            while (busy && len < 1000) begin len++; @(negedge clk); end
            chk(len == PROG, "R5 busy width", len, PROG);
        end else begin
            saw_busy = 0;
            repeat (PROG + 4) begin @(negedge clk); if (busy) saw_busy = 1; end
            chk(!saw_busy, "R7/R8 no busy window", saw_busy, 0);
        end
        repeat (2) @(negedge clk);
        exp_n = 0;
        for (int i = 0; i < 16; i++) if (exp_v[i] && exp_busy) exp_n++;
        chk(wlog_n == exp_n, "R6/R8 write count", wlog_n, exp_n);
        k = 0;
        for (int i = 0; i < 16; i++) begin
            if (exp_v[i] && exp_busy && k < wlog_n) begin
                chk(wlog_a[k] == {v.addr[10:4], 4'(i)}, "R2/R3/R6 write address",
                    wlog_a[k], {v.addr[10:4], 4'(i)});
                chk(wlog_d[k] == exp_d[i], "R4 write data", wlog_d[k], exp_d[i]);
                k++;
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!busy && !mem_we, "R1 reset outputs", {busy, mem_we}, 0);
        pulse_stop();
        chk(!busy, "R1 bare STOP after reset", busy, 0);
        repeat (2) @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            run_vec(VEC[v], v * 37);
        end

        // R8: protected STOP discards the buffer
        wlog_n = 0;
        put_byte(1'b1, 11'h1A0, 8'h5A);
        wp = 1'b1; pulse_stop(); wp = 1'b0;
        chk(!busy, "R8 protected STOP", busy, 0);
        pulse_stop();
        chk(!busy, "R8 buffer discarded", busy, 0);
        repeat (PROG + 2) @(negedge clk);
        chk(wlog_n == 0, "R8 no writes", wlog_n, 0);

        // R9 and R10: strobes during busy ignored, mask gone afterwards
        wlog_n = 0;
        put_byte(1'b1, 11'h200, 8'hAA);
        pulse_stop();
        put_byte(1'b1, 11'h345, 8'h55);
        put_byte(1'b0, 11'h345, 8'h66);
        pulse_stop();
        wait_idle();
        chk(wlog_n == 1, "R9 single committed byte", wlog_n, 1);
        chk(wlog_a[0] == 11'h200 && wlog_d[0] == 8'hAA, "R9 committed content",
            {wlog_a[0], wlog_d[0]}, {11'h200, 8'hAA});
        pulse_stop();
        chk(!busy, "R10 STOP after window", busy, 0);
        repeat (PROG + 2) @(negedge clk);
        chk(wlog_n == 1, "R9 bytes sent while busy not kept", wlog_n, 1);

        // R5: byte coinciding with STOP is dropped
        wlog_n = 0;
        byte_vld = 1'b1; byte_first = 1'b1; byte_addr = 11'h011; byte_data = 8'h99;
        stop = 1'b1;
        @(negedge clk);
        byte_vld = 1'b0; byte_first = 1'b0; stop = 1'b0;
        chk(!busy, "R5 byte with STOP dropped", busy, 0);

        // R11: new first byte discards an unfinished transaction
        wlog_n = 0;
        put_byte(1'b1, 11'h410, 8'h01);
        put_byte(1'b0, 11'h410, 8'h02);
        put_byte(1'b0, 11'h410, 8'h03);
        put_byte(1'b1, 11'h4A7, 8'h77);
        pulse_stop();
        wait_idle();
        chk(wlog_n == 1, "R11 restart write count", wlog_n, 1);
        chk(wlog_a[0] == 11'h4A7 && wlog_d[0] == 8'h77, "R11 restart content",
            {wlog_a[0], wlog_d[0]}, {11'h4A7, 8'h77});

        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule